// File: doc/BRIEF.md
# Tap-Triggered Sprite Jump Controller

This block computes the screen coordinates of a square sprite in a simple side-scrolling game. One tap on the jump button starts a full jump arc. The sprite first climbs a fixed number of pixels per game tick until it reaches a ceiling line. It then drops back down until it sits on the floor again. After the tap is seen, releasing or holding the button makes no difference until the sprite has landed.

All logic runs in the system clock domain. A counter makes a one-cycle game-tick enable every `TICK_DIV` clocks. The default of 1,666,667 gives 60 ticks per second from a 100 MHz clock. The button passes through a two-flop synchronizer before any decision uses it. An internal phase register (rest, rising, falling) records the jump, separate from the button level. The x coordinate is fixed at the start column. A downstream drawing stage reads `pos_x` and `pos_y` directly.

Top module: `jump_arc_ctrl`

## Requirements
- R1: While `rst_n` is low, and at once when it goes low (asynchronously, overriding any jump in progress), the outputs are `pos_x` = 503 and `pos_y` = 664 (floor 696 minus sprite height 32). The block returns to rest, so no jump resumes after reset is released.
- R2: `pos_y` changes only on a game tick, which occurs once every `TICK_DIV` clock cycles. During a jump, successive moves are exactly `TICK_DIV` cycles apart, except around the single turnaround tick.
- R3: At rest, a tick that sees the synchronized button high starts a jump. On each following tick, `pos_y` decreases by 10 (STEP).
- R4: The climb continues while `pos_y` > 164 (the ceiling). The first tick that finds `pos_y` not above 164 makes no move and switches to falling. With the defaults, the highest point is `pos_y` = 164.
- R5: While falling, each tick increases `pos_y` by 10, clamped so that `pos_y` never exceeds 664. A complete default jump is exactly 100 position changes.
- R6: Releasing the button after the starting tick does not shorten or stop the jump.
- R7: Button presses while rising or falling are ignored. The trajectory reverses direction exactly once per jump.
- R8: The jump state clears only on a tick where the sprite is at the floor and the synchronized button is low. Holding the button through the landing does not start another jump. A press after release starts a new one.
- R9: `pos_x` stays at 503 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset to the start position |
| jump_btn | input | 1 | Raw jump button level, asynchronous to clk |
| pos_x | output | 11 | Sprite left coordinate |
| pos_y | output | 11 | Sprite top coordinate (larger means lower on screen) |

## Verification
The hardest case to reach from the ports is a landing while the button is still held. That is the only situation where the "clear on release at floor" rule differs from a plain "clear on landing" rule. The stimulus holds the button for longer than a whole arc. It then confirms that no second climb appears before release, and that the next table entry's tap does start a fresh arc. Presses during the climb and during the descent come from vector entries with a second tap. A monitor counts every position change, step size, direction reversal and tick spacing, so an ignored press shows up as an unchanged count of changes.

// File: rtl/jump_arc_ctrl.sv
module jump_arc_ctrl #(
  parameter int TICK_DIV = 1_666_667,
  parameter int W        = 11,
  parameter int STEP     = 10,
  parameter int FLOOR_Y  = 696,
  parameter int SPRITE_H = 32,
  parameter int CEIL_Y   = 164,
  parameter int START_X  = 503
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         jump_btn,
  output logic [W-1:0] pos_x,
  output logic [W-1:0] pos_y
);
  localparam int CW     = $clog2(TICK_DIV + 1);
  localparam int REST_Y = FLOOR_Y - SPRITE_H;

  typedef enum logic [1:0] {AT_REST, RISING, FALLING} phase_t;

  logic [CW-1:0] cnt;
  logic [1:0]    btn_q;
  phase_t        phase;
  logic [W-1:0]  y;
  logic          tick, btn_s, jumping;
  logic [W-1:0]  y_down;

  assign tick    = (cnt == CW'(TICK_DIV - 1));
  assign btn_s   = btn_q[1];
  assign jumping = (phase != AT_REST);
  assign y_down  = (W'(REST_Y) - y > W'(STEP)) ? y + W'(STEP) : W'(REST_Y);
  assign pos_x   = W'(START_X);
  assign pos_y   = y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      btn_q <= '0;
      phase <= AT_REST;
      y     <= W'(REST_Y);
    end else begin
      btn_q <= {btn_q[0], jump_btn};
      cnt   <= tick ? '0 : cnt + CW'(1);
      if (tick) begin
        unique case (phase)
          AT_REST: if (btn_s) phase <= RISING;
          RISING:  if (y > W'(CEIL_Y)) y <= y - W'(STEP);
                   else phase <= FALLING;
          FALLING: if (y < W'(REST_Y)) y <= y_down;
                   else if (!btn_s) phase <= AT_REST;
          default: phase <= AT_REST;
        endcase
      end
    end
  end
endmodule

// File: rtl/jump_arc_ctrl_chk.sv
module jump_arc_ctrl_chk #(
  parameter int W      = 11,
  parameter int STEP   = 10,
  parameter int REST_Y = 664
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         btn_s,
  input logic         jumping,
  input logic [W-1:0] pos_y
);
  p_move_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(pos_y));

  p_step_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos_y) |-> (pos_y + W'(STEP) == $past(pos_y)) ||
                        (pos_y > $past(pos_y) && pos_y - $past(pos_y) <= W'(STEP)));

  p_floor_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_y <= W'(REST_Y));

  p_start_at_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jumping) |-> $past(btn_s) && $past(pos_y) == W'(REST_Y));

  p_clear_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jumping) |-> !$past(btn_s) && $past(pos_y) == W'(REST_Y));
endmodule

bind jump_arc_ctrl jump_arc_ctrl_chk #(.W(W), .STEP(STEP), .REST_Y(REST_Y)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .btn_s(btn_s),
  .jumping(jumping), .pos_y(pos_y));

// File: tb/jump_arc_ctrl_tb.sv
module jump_arc_ctrl_tb;
  localparam int DIV = 4;
  localparam int W   = 11;

  logic clk = 1'b0, rst_n = 1'b0, jump_btn = 1'b0;
  logic [W-1:0] pos_x, pos_y;
  int errors = 0, checks = 0, cyc = 0;

  jump_arc_ctrl #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .jump_btn(jump_btn), .pos_x(pos_x), .pos_y(pos_y));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // trajectory monitor
  logic mon_on = 1'b0;
  int nchg, bad_step, odd_int, revs, min_y, max_y, last_cyc, dir, xbad;
  logic [W-1:0] prev_y;
  always @(negedge clk) if (mon_on) begin
    if (pos_x != W'(503)) xbad++;
    if (pos_y != prev_y) begin
      if (pos_y + W'(10) == prev_y) begin
        if (dir == 1) revs++;
        dir = -1;
      end else if (pos_y == prev_y + W'(10)) begin
        if (dir == -1) revs++;
        dir = 1;
      end else bad_step++;
      if (nchg > 0 && cyc - last_cyc != DIV) odd_int++;
      last_cyc = cyc;
      nchg++;
      if (int'(pos_y) < min_y) min_y = int'(pos_y);
      if (int'(pos_y) > max_y) max_y = int'(pos_y);
    end
    prev_y = pos_y;
  end

  task automatic mon_start();
    @(negedge clk);
    nchg = 0; bad_step = 0; odd_int = 0; revs = 0; dir = 0; xbad = 0;
    min_y = 9999; max_y = 0; last_cyc = 0; prev_y = pos_y;
    mon_on = 1'b1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // press_len, repress_at, repress_len, expected changes
  localparam int VEC [4][4] = '{
    '{6,   0,   0, 100},
    '{600, 0,   0, 100},
    '{6,   250, 6, 100},
    '{6,   100, 6, 100}
  };

  initial begin
    #(5 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clocks(3);
    check("R1 reset x", int'(pos_x), 503);
    check("R1 reset y", int'(pos_y), 664);
    rst_n = 1'b1;
    clocks(5);

    for (int v = 0; v < 4; v++) begin
      int t;
      mon_start();
      t = 0;
      jump_btn = 1'b1;
      clocks(VEC[v][0]); t += VEC[v][0];
      jump_btn = 1'b0;
      if (VEC[v][1] > 0) begin
        clocks(VEC[v][1] - t); t = VEC[v][1];
        jump_btn = 1'b1;
        clocks(VEC[v][2]); t += VEC[v][2];
        jump_btn = 1'b0;
      end
      clocks(700 - t);
      mon_on = 1'b0;
      check("R3 R6 R7 R8 change count", nchg, VEC[v][3]);
      check("R4 peak y", min_y, 164);
      check("R5 lowest y", max_y, 664);
      check("R5 landed y", int'(pos_y), 664);
      check("R5 step size errors", bad_step, 0);
      check("R7 direction reversals", revs, 1);
      check("R2 uneven tick spacing", odd_int, 1);
      check("R9 x deviations", xbad, 0);
    end

    // R8: landing while held, no second arc before release
    mon_start();
    jump_btn = 1'b1;
    clocks(900);
    check("R8 held-through-landing changes", nchg, 100);
    check("R8 at floor while held", int'(pos_y), 664);
    jump_btn = 1'b0;
    clocks(20);
    jump_btn = 1'b1;
    clocks(6);
    jump_btn = 1'b0;
    clocks(700);
    mon_on = 1'b0;
    check("R8 new arc after release", nchg, 200);

    // R1: reset mid-jump
    jump_btn = 1'b1;
    clocks(6);
    jump_btn = 1'b0;
    clocks(100);
    check("R1 airborne before reset", int'(pos_y < W'(664)), 1);
    rst_n = 1'b0;
    #1;
    check("R1 async y", int'(pos_y), 664);
    check("R1 async x", int'(pos_x), 503);
    clocks(3);
    rst_n = 1'b1;
    mon_start();
    clocks(300);
    mon_on = 1'b0;
    check("R1 no resume after reset", nchg, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule